// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is the first-level data cache of a processor that issues 34-bit byte addresses and moves 64-bit words. It holds 8 KB as 256 lines of 32 bytes. Each line has a valid bit and a 21-bit tag. A lookup reads the tag, the valid bit and the data word in the same cycle. A read hit therefore returns the word combinationally, with no stall.

A read miss raises the stall at once and starts the refill sequencer. The sequencer fetches the line from the lower memory in two 16-byte beats. Each beat holds its address for a fixed five cycles and is sampled on the last of them. After the second beat the tag and valid bit are written, and the held request then hits.

Writes follow a write-through, no-write-allocate policy. Every write is presented on the write-buffer port. A hit also merges the enabled bytes into the cached word. A miss leaves the cache alone. While the buffer reports full, the write is stalled.

Top module: `dc_wt_cache`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) invalidates every line. After reset, the first read of any address misses. While no request is presented, `cpu_stall`, `mem_rd_req` and `wb_valid` are low.
- R2: Address bits [12:5] select the line and bits [33:13] form the tag. A read hits only when that line is valid and its stored tag equals the address tag. A read to the same line with a different tag misses, and its refill replaces the resident line.
- R3: On a read hit, `cpu_stall` is low in the same cycle. `cpu_rdata` carries the 64-bit word of the line selected by address bits [4:3], and `mem_rd_req` stays low.
- R4: A read miss keeps `cpu_stall` high for 11 cycles: the miss cycle and ten refill cycles. `mem_rd_req` is high in the ten refill cycles. In the first five, `mem_rd_addr` is the 32-byte-aligned line base. In the last five it is the line base plus 16.
- R5: Each beat is sampled in its fifth cycle. Bits [63:0] of `mem_rd_data` become the lower of the two words the beat covers, and bits [127:64] the upper. Once the refill ends, the held read hits in the next cycle and returns the refilled word.
- R6: A write hit accepted by the buffer replaces byte i of the addressed word, bits [8i+7:8i], for every set bit i of `cpu_be`. In the same cycle `wb_valid` is high, and `wb_addr`, `wb_data` and `wb_be` equal the processor's address, data and byte mask.
- R7: A write miss is forwarded on the write-buffer port in the same way. It changes no line: a line resident at the same index still hits with its old data, and a later read of the written address misses. The write starts no refill.
- R8: While `wb_full` is high, a write holds `cpu_stall` and `wb_valid` high and does not update the cache. The write is accepted, with `cpu_stall` low, in the first cycle that `wb_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 34 | Byte address |
| cpu_wdata | input | 64 | Write data |
| cpu_be | input | 8 | Byte enables for writes |
| cpu_rdata | output | 64 | Read word |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_rd_req | output | 1 | Lower memory beat request |
| mem_rd_addr | output | 34 | 16-byte-aligned beat address |
| mem_rd_data | input | 128 | Beat data, valid in the fifth cycle of a beat |
| wb_valid | output | 1 | Write presented to the write buffer |
| wb_addr | output | 34 | Write address |
| wb_data | output | 64 | Write data |
| wb_be | output | 8 | Write byte enables |
| wb_full | input | 1 | Write buffer cannot accept |

## Verification
The hardest case to reach is a write miss aimed at an index that already holds a valid line under another tag. It is the only way to tell a no-write-allocate cache from one that silently overwrites or invalidates the resident line. The stimulus first refills a line, writes to a second tag at the same index, re-reads the resident line expecting a stall-free hit with unchanged data, and then reads the written address, expecting a full refill. The lower memory stub returns valid data only in the fifth cycle of an unchanged beat address, so a sequencer that samples early or late stores visibly wrong words.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic {
      RF_IDLE = 1'b0,
      RF_FILL = 1'b1
   } rf_state_t;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
   parameter int unsigned LINES = 256,
   parameter int unsigned TAG_W = 21,
   localparam int unsigned IDX_W = dc_pkg::sel_width(LINES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
   parameter int unsigned LINES      = 256,
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned WORD_BYTES = 8,
   parameter int unsigned BEAT_BYTES = 16,
   localparam int unsigned IDX_W  = dc_pkg::sel_width(LINES),
   localparam int unsigned WORD_W = 8 * WORD_BYTES,
   localparam int unsigned BEAT_W = 8 * BEAT_BYTES,
   localparam int unsigned WPL    = LINE_BYTES / WORD_BYTES,
   localparam int unsigned WPB    = BEAT_BYTES / WORD_BYTES,
   localparam int unsigned BEATS  = LINE_BYTES / BEAT_BYTES,
   localparam int unsigned WSEL_W = dc_pkg::sel_width(WPL),
   localparam int unsigned BSEL_W = dc_pkg::sel_width(BEATS)
) (
   input  logic                  clk,
   input  logic [IDX_W-1:0]      rd_idx,
   input  logic [WSEL_W-1:0]     rd_wsel,
   output logic [WORD_W-1:0]     rd_word,
   input  logic                  cw_en,
   input  logic [IDX_W-1:0]      cw_idx,
   input  logic [WSEL_W-1:0]     cw_wsel,
   input  logic [WORD_W-1:0]     cw_data,
   input  logic [WORD_BYTES-1:0] cw_be,
   input  logic                  fill_en,
   input  logic [IDX_W-1:0]      fill_idx,
   input  logic [BSEL_W-1:0]     fill_beat,
   input  logic [BEAT_W-1:0]     fill_data
);
   logic [WORD_W-1:0] lane_rd [WPL];

   for (genvar w = 0; w < WPL; w++) begin : g_lane
      localparam int unsigned LANE_BEAT = w / WPB;
      localparam int unsigned LANE_POS  = w % WPB;
      logic [WORD_W-1:0] lane_q [LINES];

      always_ff @(posedge clk) begin
         if (fill_en && fill_beat == BSEL_W'(LANE_BEAT)) begin
            lane_q[fill_idx] <= fill_data[LANE_POS*WORD_W +: WORD_W];
         end else if (cw_en && cw_wsel == WSEL_W'(w)) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
               if (cw_be[b]) begin
                  lane_q[cw_idx][8*b +: 8] <= cw_data[8*b +: 8];
               end
            end
         end
      end

      assign lane_rd[w] = lane_q[rd_idx];
   end

   assign rd_word = lane_rd[rd_wsel];
endmodule

// File: rtl/dc_refill_seq.sv
module dc_refill_seq #(
   parameter int unsigned ADDR_W      = 34,
   parameter int unsigned LINE_BYTES  = 32,
   parameter int unsigned BEAT_BYTES  = 16,
   parameter int unsigned BEAT_CYCLES = 5,
   localparam int unsigned OFS_W    = $clog2(LINE_BYTES),
   localparam int unsigned BEAT_OFS = $clog2(BEAT_BYTES),
   localparam int unsigned LN_W     = ADDR_W - OFS_W,
   localparam int unsigned BEATS    = LINE_BYTES / BEAT_BYTES,
   localparam int unsigned BSEL_W   = dc_pkg::sel_width(BEATS),
   localparam int unsigned CNT_W    = dc_pkg::sel_width(BEAT_CYCLES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [LN_W-1:0]   start_line,
   output logic              busy,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   output logic              fill_en,
   output logic              fill_last,
   output logic [BSEL_W-1:0] fill_beat,
   output logic [LN_W-1:0]   fill_line
);
   import dc_pkg::*;

   rf_state_t         state_q;
   logic [BSEL_W-1:0] beat_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [LN_W-1:0]   line_q;
   logic              beat_end;

   assign busy      = (state_q == RF_FILL);
   assign beat_end  = busy && (cnt_q == CNT_W'(BEAT_CYCLES - 1));
   assign fill_en   = beat_end;
   assign fill_last = beat_end && (beat_q == BSEL_W'(BEATS - 1));
   assign fill_beat = beat_q;
   assign fill_line = line_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RF_IDLE;
         beat_q  <= '0;
         cnt_q   <= '0;
         line_q  <= '0;
      end else begin
         case (state_q)
            RF_IDLE: begin
               if (start) begin
                  state_q <= RF_FILL;
                  line_q  <= start_line;
                  beat_q  <= '0;
                  cnt_q   <= '0;
               end
            end
            RF_FILL: begin
               if (beat_end) begin
                  cnt_q <= '0;
                  if (fill_last) begin
                     state_q <= RF_IDLE;
                     beat_q  <= '0;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= RF_IDLE;
         endcase
      end
   end

   assign mem_rd_req  = busy;
   assign mem_rd_addr = ADDR_W'({line_q, OFS_W'(0)}) | (ADDR_W'(beat_q) << BEAT_OFS);
endmodule

// File: rtl/dc_wt_cache.sv
module dc_wt_cache #(
   parameter int unsigned ADDR_W      = 34,
   parameter int unsigned LINES       = 256,
   parameter int unsigned LINE_BYTES  = 32,
   parameter int unsigned WORD_BYTES  = 8,
   parameter int unsigned BEAT_BYTES  = 16,
   parameter int unsigned BEAT_CYCLES = 5,
   localparam int unsigned OFS_W    = $clog2(LINE_BYTES),
   localparam int unsigned IDX_W    = dc_pkg::sel_width(LINES),
   localparam int unsigned TAG_W    = ADDR_W - IDX_W - OFS_W,
   localparam int unsigned LN_W     = ADDR_W - OFS_W,
   localparam int unsigned WORD_W   = 8 * WORD_BYTES,
   localparam int unsigned BEAT_W   = 8 * BEAT_BYTES,
   localparam int unsigned WB_OFS   = $clog2(WORD_BYTES),
   localparam int unsigned WPL      = LINE_BYTES / WORD_BYTES,
   localparam int unsigned WSEL_W   = dc_pkg::sel_width(WPL),
   localparam int unsigned BEATS    = LINE_BYTES / BEAT_BYTES,
   localparam int unsigned BSEL_W   = dc_pkg::sel_width(BEATS)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cpu_req,
   input  logic                  cpu_we,
   input  logic [ADDR_W-1:0]     cpu_addr,
   input  logic [WORD_W-1:0]     cpu_wdata,
   input  logic [WORD_BYTES-1:0] cpu_be,
   output logic [WORD_W-1:0]     cpu_rdata,
   output logic                  cpu_stall,
   output logic                  mem_rd_req,
   output logic [ADDR_W-1:0]     mem_rd_addr,
   input  logic [BEAT_W-1:0]     mem_rd_data,
   output logic                  wb_valid,
   output logic [ADDR_W-1:0]     wb_addr,
   output logic [WORD_W-1:0]     wb_data,
   output logic [WORD_BYTES-1:0] wb_be,
   input  logic                  wb_full
);
   if (TAG_W < 1) begin : g_err_tag
      $error("address too narrow for the chosen geometry");
   end
   if ((LINE_BYTES % BEAT_BYTES) != 0 || BEAT_BYTES < WORD_BYTES) begin : g_err_beat
      $error("beat must hold whole words and divide the line");
   end
   if ((1 << OFS_W) != LINE_BYTES || (1 << IDX_W) != LINES) begin : g_err_pow2
      $error("line size and line count must be powers of two");
   end
   if (BEAT_CYCLES < 1) begin : g_err_cyc
      $error("a beat needs at least one cycle");
   end

   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_idx;
   logic [WSEL_W-1:0] req_wsel;
   logic [LN_W-1:0]   req_line;
   logic              line_valid;
   logic [TAG_W-1:0]  line_tag;
   logic              hit;
   logic              busy;
   logic              fill_en;
   logic              fill_last;
   logic [BSEL_W-1:0] fill_beat;
   logic [LN_W-1:0]   fill_line;
   logic              rd_miss;
   logic              wr_req;
   logic              wr_take;

   assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
   assign req_idx  = cpu_addr[OFS_W +: IDX_W];
   assign req_wsel = cpu_addr[WB_OFS +: WSEL_W];
   assign req_line = cpu_addr[ADDR_W-1 -: LN_W];

   assign hit     = line_valid && (line_tag == req_tag);
   assign rd_miss = cpu_req && !cpu_we && !hit && !busy;
   assign wr_req  = cpu_req && cpu_we && !busy;
   assign wr_take = wr_req && !wb_full;

   dc_tag_store #(
      .LINES (LINES),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk      (clk),
      .rst      (rst),
      .rd_idx   (req_idx),
      .rd_valid (line_valid),
      .rd_tag   (line_tag),
      .wr_en    (fill_last),
      .wr_idx   (fill_line[IDX_W-1:0]),
      .wr_tag   (fill_line[LN_W-1 -: TAG_W])
   );

   dc_data_store #(
      .LINES      (LINES),
      .LINE_BYTES (LINE_BYTES),
      .WORD_BYTES (WORD_BYTES),
      .BEAT_BYTES (BEAT_BYTES)
   ) u_data (
      .clk       (clk),
      .rd_idx    (req_idx),
      .rd_wsel   (req_wsel),
      .rd_word   (cpu_rdata),
      .cw_en     (wr_take && hit),
      .cw_idx    (req_idx),
      .cw_wsel   (req_wsel),
      .cw_data   (cpu_wdata),
      .cw_be     (cpu_be),
      .fill_en   (fill_en),
      .fill_idx  (fill_line[IDX_W-1:0]),
      .fill_beat (fill_beat),
      .fill_data (mem_rd_data)
   );

   dc_refill_seq #(
      .ADDR_W      (ADDR_W),
      .LINE_BYTES  (LINE_BYTES),
      .BEAT_BYTES  (BEAT_BYTES),
      .BEAT_CYCLES (BEAT_CYCLES)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .start       (rd_miss),
      .start_line  (req_line),
      .busy        (busy),
      .mem_rd_req  (mem_rd_req),
      .mem_rd_addr (mem_rd_addr),
      .fill_en     (fill_en),
      .fill_last   (fill_last),
      .fill_beat   (fill_beat),
      .fill_line   (fill_line)
   );

   assign cpu_stall = busy || rd_miss || (wr_req && wb_full);
   assign wb_valid  = wr_req;
   assign wb_addr   = cpu_addr;
   assign wb_data   = cpu_wdata;
   assign wb_be     = cpu_be;
endmodule

// File: rtl/dc_wt_cache_chk.sv
module dc_wt_cache_chk #(
   parameter int unsigned ADDR_W     = 34,
   parameter int unsigned BEAT_BYTES = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_stall,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              wb_valid,
   input logic              wb_full
);
   // R4: within a refill the beat address holds or steps by one beat
   assert_beat_addr_R4: assert property (@(posedge clk) disable iff (rst)
      (mem_rd_req && $past(mem_rd_req)) |->
         (mem_rd_addr == $past(mem_rd_addr) ||
          mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(BEAT_BYTES)));

   // R4: the processor is held for as long as memory is being read
   assert_stall_in_refill_R4: assert property (@(posedge clk) disable iff (rst)
      mem_rd_req |-> cpu_stall);

   // R3: a completed read never coincides with a memory fetch
   assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (rst)
      (cpu_req && !cpu_we && !cpu_stall) |-> !mem_rd_req);

   // R7: a write never launches a refill
   assert_write_no_refill_R7: assert property (@(posedge clk) disable iff (rst)
      (cpu_req && cpu_we && !mem_rd_req) |=> !mem_rd_req);

   // R8: a write facing a full buffer is stalled
   assert_full_stalls_R8: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && wb_full) |-> cpu_stall);

   // R1: the cycle after reset no read completes without a miss
   assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && cpu_req && !cpu_we) |-> cpu_stall);
endmodule

bind dc_wt_cache dc_wt_cache_chk #(
   .ADDR_W     (ADDR_W),
   .BEAT_BYTES (BEAT_BYTES)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .cpu_req     (cpu_req),
   .cpu_we      (cpu_we),
   .cpu_stall   (cpu_stall),
   .mem_rd_req  (mem_rd_req),
   .mem_rd_addr (mem_rd_addr),
   .wb_valid    (wb_valid),
   .wb_full     (wb_full)
);

// File: tb/dc_wt_cache_tb.sv
`timescale 1ns/1ps
module dc_wt_cache_tb;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cpu_req = 1'b0;
   logic         cpu_we = 1'b0;
   logic [33:0]  cpu_addr = '0;
   logic [63:0]  cpu_wdata = '0;
   logic [7:0]   cpu_be = '0;
   logic [63:0]  cpu_rdata;
   logic         cpu_stall;
   logic         mem_rd_req;
   logic [33:0]  mem_rd_addr;
   logic [127:0] mem_rd_data;
   logic         wb_valid;
   logic [33:0]  wb_addr;
   logic [63:0]  wb_data;
   logic [7:0]   wb_be;
   logic         wb_full = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [63:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   dc_wt_cache u_dut (
      .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_be(wb_be),
      .wb_full(wb_full)
   );

   function automatic logic [63:0] mw(input logic [33:0] a);
      return {a[31:0] ^ 32'h5A5A_C3C3, ~a[31:0] ^ {30'b0, a[33:32]}};
   endfunction

   function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n,
                                         input logic [7:0] be);
      logic [63:0] m;
      for (int i = 0; i < 8; i++) m[8*i +: 8] = {8{be[i]}};
      return (o & ~m) | (n & m);
   endfunction

   // lower memory stub: data valid only in the fifth cycle of a steady beat address
   logic [33:0] stub_last;
   int          stub_cnt;
   always_ff @(posedge clk) begin
      stub_last <= mem_rd_addr;
      if (!mem_rd_req) stub_cnt <= 0;
      else if (mem_rd_addr != stub_last) stub_cnt <= 1;
      else stub_cnt <= stub_cnt + 1;
   end
   assign mem_rd_data = (mem_rd_req && mem_rd_addr == stub_last && stub_cnt == 4)
                        ? {mw(mem_rd_addr + 34'd8), mw(mem_rd_addr)}
                        : {4{32'hDEAD_BEEF}};

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops an expectation for every completed read
   always @(negedge clk) begin
      #2;
      if (!rst && cpu_req && !cpu_we && !cpu_stall) begin
         if (exp_q.size() == 0) begin
            chk(0, "R3 unexpected read", cpu_rdata, 64'h0);
         end else begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(cpu_rdata == e, t, cpu_rdata, e);
         end
      end
   end

   task automatic do_read(input logic [33:0] a, input logic [63:0] exp,
                          input bit miss, input string req);
      int n = 0, nb0 = 0, nb1 = 0;
      logic [33:0] base;
      base = {a[33:5], 5'b0};
      exp_q.push_back(exp);
      tag_q.push_back({req, " read data"});
      @(negedge clk);
      cpu_req = 1; cpu_we = 0; cpu_addr = a;
      #1;
      if (cpu_stall) n = 1;
      while (cpu_stall && n < 40) begin
         @(negedge clk); #1;
         if (mem_rd_req) begin
            if (mem_rd_addr == base) nb0++;
            else if (mem_rd_addr == base + 34'd16) nb1++;
         end
         if (cpu_stall) n++;
      end
      chk(n == (miss ? 11 : 0), {req, " stall cycles"}, 64'(n), miss ? 64'd11 : 64'd0);
      if (miss) begin
         chk(nb0 == 5, "R4 beat0 cycles at line base", 64'(nb0), 64'd5);
         chk(nb1 == 5, "R4 beat1 cycles at base+16", 64'(nb1), 64'd5);
      end else begin
         chk(!mem_rd_req, "R3 no fetch on hit", 64'(mem_rd_req), 64'd0);
      end
      @(negedge clk);
      cpu_req = 0;
   endtask

   task automatic do_write(input logic [33:0] a, input logic [63:0] d,
                           input logic [7:0] be, input int full_cyc, input string req);
      @(negedge clk);
      cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; cpu_be = be;
      wb_full = (full_cyc > 0);
      for (int i = 0; i < full_cyc; i++) begin
         #1;
         chk(cpu_stall, "R8 stall while buffer full", 64'(cpu_stall), 64'd1);
         chk(wb_valid, "R8 wb_valid held while full", 64'(wb_valid), 64'd1);
         @(negedge clk);
      end
      wb_full = 0;
      #1;
      chk(!cpu_stall, {req, " write accepted"}, 64'(cpu_stall), 64'd0);
      chk(wb_valid && wb_addr == a, {req, " wb address"}, 64'(wb_addr), 64'(a));
      chk(wb_data == d && wb_be == be, {req, " wb data"}, wb_data, d);
      @(negedge clk);
      cpu_req = 0; cpu_we = 0;
      #1;
      chk(!mem_rd_req, "R7 write starts no refill", 64'(mem_rd_req), 64'd0);
   endtask

   localparam logic [33:0] A0 = {21'h0ABCD, 8'h33, 5'h00};
   localparam logic [33:0] A1 = {21'h1F00F, 8'h33, 5'h00};
   localparam logic [33:0] A2 = {21'h00001, 8'hFF, 5'h00};
   localparam logic [33:0] A3 = {21'h12345, 8'h00, 5'h00};

   initial begin
      logic [63:0] d0, d1;
      repeat (4) @(negedge clk);
      rst = 0;
      #1;
      chk(!cpu_stall && !mem_rd_req && !wb_valid, "R1 idle after reset",
          {61'b0, cpu_stall, mem_rd_req, wb_valid}, 64'd0);

      do_read(A0, mw(A0), 1, "R1 R4 R5 first read misses");
      do_read(A0 + 34'd8,  mw(A0 + 34'd8),  0, "R3 R5 word1 hit");
      do_read(A0 + 34'd16, mw(A0 + 34'd16), 0, "R3 R5 word2 hit");
      do_read(A0 + 34'd24, mw(A0 + 34'd24), 0, "R3 R5 word3 hit");

      do_read(A1 + 34'd24, mw(A1 + 34'd24), 1, "R2 tag conflict miss");
      do_read(A0, mw(A0), 1, "R2 evicted line misses");
      do_read(A2 + 34'd16, mw(A2 + 34'd16), 1, "R2 top index miss");
      do_read(A3 + 34'd8,  mw(A3 + 34'd8),  1, "R2 index zero miss");
      do_read(A2 + 34'd16, mw(A2 + 34'd16), 0, "R3 top index hit");

      d0 = 64'h1122_3344_5566_7788;
      do_write(A0 + 34'd8, d0, 8'hF0, 0, "R6 write hit");
      do_read(A0 + 34'd8, merge(mw(A0 + 34'd8), d0, 8'hF0), 0, "R6 merged bytes");

      do_write(A1, 64'hFFFF_0000_FFFF_0000, 8'hFF, 0, "R7 write miss");
      do_read(A0 + 34'd8, merge(mw(A0 + 34'd8), d0, 8'hF0), 0, "R7 resident line kept");
      do_read(A1, mw(A1), 1, "R7 write miss did not allocate");

      d1 = 64'hCAFE_F00D_0BAD_BEEF;
      do_write(A1 + 34'd16, d1, 8'h01, 3, "R8 write after full");
      do_read(A1 + 34'd16, merge(mw(A1 + 34'd16), d1, 8'h01), 0, "R8 write landed once");

      @(negedge clk);
      rst = 1;
      @(negedge clk);
      rst = 0;
      do_read(A1 + 34'd16, mw(A1 + 34'd16), 1, "R1 reset invalidates");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R3 all reads completed", 64'(exp_q.size()), 64'd0);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=0", 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule